// File: doc/BRIEF.md
# Embedded-Sync Video Stream Decoder

This block takes a parallel digital video stream in which line and frame timing travel as code words inside the data, not on separate sync wires. The pixel clock is its only clock, and it has no external sync inputs. The block watches one component lane for a timing code. A timing code is three preamble words, all-ones, all-zeros and all-zeros, followed by a status word. The block removes every code word from the pixel output and also suppresses the blanking data between lines. From the status bits it rebuilds internal vertical sync, horizontal sync, a field flag and a frame-start pulse, together with a pixel-valid strobe.

A mode input selects the stream format. In single-lane mode one component arrives per clock on the low half of the data bus. In dual-lane mode two components arrive per clock: luma on the low half and chroma on the high half. Timing codes are always searched for on the low (luma) lane. A word that might begin a preamble can only be judged three words later, so every word passes through a short delay line. A pixel driven into the block leaves it at the fifth rising edge.

Top module: `esv_decoder`

## Requirements
- R1: While reset is held and after it is released, pix_valid_o, hsync_o, field_o and frame_start_o are 0 and vsync_o is 1.
- R2: A timing code is the low-lane sequence all-ones, all-zeros, all-zeros, then a status word whose MSB is 1. In the status word, bit CW-2 is the field flag F, bit CW-3 is the vertical blanking flag V and bit CW-4 is H. H=0 marks a start code and H=1 marks an end code.
- R3: pix_valid_o is 1 only for words strictly between a start code with V=0 and the next end code. A word driven before rising edge n appears on pix_data_o and pix_valid_o after edge n+4. None of the four code words is ever marked valid.
- R4: Blanking words that arrive between an end code and the next start code are never marked valid.
- R5: A start code with V=1 does not open an active line, so the words after it are not marked valid.
- R6: vsync_o takes the V flag of the latest code. It updates at the edge after the edge that samples the status word.
- R7: hsync_o goes to 1 on a start code and back to 0 on an end code, with the same timing as R6.
- R8: field_o takes the F flag of the latest code, with the same timing as R6.
- R9: frame_start_o is a one-cycle pulse, timed as in R6, on the first start code with V=0 that follows a code with V=1. Reset counts as V=1, so the first such start code after reset also pulses. Later start codes in the same frame do not pulse.
- R10: An incomplete preamble (all-ones, or all-ones then all-zeros, followed by another value) is not a code. Those words are forwarded unchanged, marked valid or not according to the current line state.
- R11: In single-lane mode the high half of pix_data_o is 0. In dual-lane mode both halves are forwarded, and the high lane is never examined for codes.
- R12: A preamble followed by a status word whose MSB is 0 is not a code. All four words are treated as ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode_i | input | 1 | 1 = two components per clock, 0 = one |
| data_i | input | 2*CW | Stream word: low half luma/single lane, high half chroma |
| pix_data_o | output | 2*CW | Forwarded pixel word |
| pix_valid_o | output | 1 | Word on pix_data_o is active video |
| vsync_o | output | 1 | Regenerated vertical blanking |
| hsync_o | output | 1 | Regenerated active-line sync |
| field_o | output | 1 | Field flag of the latest code |
| frame_start_o | output | 1 | One-cycle pulse at the first active line of a frame |

## Verification
Pixel results lag their input word by five rising edges, four through the delay line and one through the output register. The sync, field and frame-start outputs change one edge after the edge that samples a status word. The bench drives inputs on the falling edge and compares on a later falling edge. In the table walk, the result for entry k is read on iteration k+5. In the directed tests, each code is followed by exactly one fill word, and the flags are read on the falling edge after that, so the frame-start pulse is seen in its only cycle.

// File: rtl/esv_pkg.sv
package esv_pkg;

    // Preamble words preceding every status word
    localparam int PREAMBLE_LEN = 3;

    // Flag positions counted down from the status word MSB
    localparam int F_FROM_MSB = 1;
    localparam int V_FROM_MSB = 2;
    localparam int H_FROM_MSB = 3;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } esv_flags_t;

    function automatic logic is_start(input esv_flags_t fl);
        return ~fl.h;
    endfunction

    function automatic logic opens_line(input esv_flags_t fl);
        return ~fl.h & ~fl.v;
    endfunction

endpackage

// File: rtl/esv_delay_line.sv
module esv_delay_line #(
    parameter int CW    = 10,
    parameter int DW    = 2 * CW,
    parameter int DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [DW-1:0]               din,
    input  logic                        kill_all,
    output logic [DEPTH-1:0][CW-1:0]    tap_lane,
    output logic [DW-1:0]               tail_word,
    output logic                        tail_kill
);

    logic [DEPTH-1:0][DW-1:0] stage_q;
    logic [DEPTH-1:0]         kill_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= '0;
                    else     stage_q[i] <= din;
                end
                assign kill_q[i] = 1'b0;
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) begin
                        stage_q[i] <= '0;
                        kill_q[i]  <= 1'b0;
                    end else begin
                        stage_q[i] <= stage_q[i-1];
                        kill_q[i]  <= kill_q[i-1] | kill_all;
                    end
                end
            end
            assign tap_lane[i] = stage_q[i][CW-1:0];
        end
    endgenerate

    assign tail_word = stage_q[DEPTH-1];
    assign tail_kill = kill_q[DEPTH-1];

endmodule

// File: rtl/esv_code_detect.sv
module esv_code_detect
    import esv_pkg::*;
#(
    parameter int CW    = 10,
    parameter int DEPTH = PREAMBLE_LEN + 1
) (
    input  logic [DEPTH-1:0][CW-1:0] tap_lane,
    input  logic                     blocked,
    output logic                     hit,
    output esv_flags_t               flags
);

    logic [CW-1:0] status_w;
    logic          pre_ok;

    assign status_w = tap_lane[0];

    always_comb begin
        pre_ok = (tap_lane[DEPTH-1] == {CW{1'b1}});
        for (int k = 1; k < DEPTH - 1; k++) begin
            pre_ok = pre_ok & (tap_lane[k] == '0);
        end
    end

    assign hit     = pre_ok & status_w[CW-1] & ~blocked;
    assign flags.f = status_w[CW-1-F_FROM_MSB];
    assign flags.v = status_w[CW-1-V_FROM_MSB];
    assign flags.h = status_w[CW-1-H_FROM_MSB];

endmodule

// File: rtl/esv_timing_ctrl.sv
module esv_timing_ctrl
    import esv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  esv_flags_t flags,
    output logic       line_active,
    output logic       vsync,
    output logic       hsync,
    output logic       field,
    output logic       frame_start
);

    logic armed_q;
    logic arm_now;

    assign arm_now = armed_q | (vsync & ~flags.v);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_active <= 1'b0;
            vsync       <= 1'b1;
            hsync       <= 1'b0;
            field       <= 1'b0;
            frame_start <= 1'b0;
            armed_q     <= 1'b0;
        end else if (hit) begin
            line_active <= opens_line(flags);
            vsync       <= flags.v;
            hsync       <= is_start(flags);
            field       <= flags.f;
            frame_start <= opens_line(flags) & arm_now;
            armed_q     <= arm_now & ~flags.v & ~is_start(flags);
        end else begin
            frame_start <= 1'b0;
        end
    end

endmodule

// File: rtl/esv_decoder.sv
module esv_decoder
    import esv_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dual_mode_i,
    input  logic [2*CW-1:0] data_i,
    output logic [2*CW-1:0] pix_data_o,
    output logic            pix_valid_o,
    output logic            vsync_o,
    output logic            hsync_o,
    output logic            field_o,
    output logic            frame_start_o
);

    localparam int DW    = 2 * CW;
    localparam int DEPTH = PREAMBLE_LEN + 1;

    logic [DEPTH-1:0][CW-1:0] tap_lane;
    logic [DW-1:0]            tail_word;
    logic                     tail_kill;
    logic                     code_hit;
    esv_flags_t               code_flags;
    logic                     line_active;

    esv_delay_line #(.CW(CW), .DW(DW), .DEPTH(DEPTH)) u_delay (
        .clk       (clk),
        .rst       (rst),
        .din       (data_i),
        .kill_all  (code_hit),
        .tap_lane  (tap_lane),
        .tail_word (tail_word),
        .tail_kill (tail_kill)
    );

    esv_code_detect #(.CW(CW), .DEPTH(DEPTH)) u_detect (
        .tap_lane (tap_lane),
        .blocked  (tail_kill),
        .hit      (code_hit),
        .flags    (code_flags)
    );

    esv_timing_ctrl u_timing (
        .clk         (clk),
        .rst         (rst),
        .hit         (code_hit),
        .flags       (code_flags),
        .line_active (line_active),
        .vsync       (vsync_o),
        .hsync       (hsync_o),
        .field       (field_o),
        .frame_start (frame_start_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_data_o  <= '0;
            pix_valid_o <= 1'b0;
        end else begin
            pix_valid_o <= line_active & ~tail_kill & ~code_hit;
            pix_data_o  <= dual_mode_i ? tail_word : {{CW{1'b0}}, tail_word[CW-1:0]};
        end
    end

endmodule

// File: rtl/esv_checker.sv
module esv_checker #(
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          dual_mode_i,
    input logic [CW-1:0] pix_upper,
    input logic          pix_valid_o,
    input logic          vsync_o,
    input logic          hsync_o,
    input logic          frame_start_o
);

    AST_VALID_IN_LINE: assert property (@(posedge clk) disable iff (rst)
        pix_valid_o |-> hsync_o) else $error("valid outside line"); // R3

    AST_VALID_NOT_VBLANK: assert property (@(posedge clk) disable iff (rst)
        pix_valid_o |-> !vsync_o) else $error("valid in vblank"); // R5

    AST_CODE_WORD_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_o) |=> !pix_valid_o) else $error("code word valid"); // R3

    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |=> !frame_start_o) else $error("frame start too long"); // R9

    AST_FS_CONTEXT: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |-> (hsync_o && !vsync_o)) else $error("frame start context"); // R9

    AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$past(dual_mode_i) |-> (pix_upper == '0)) else $error("upper lane leak"); // R11

endmodule

bind esv_decoder esv_checker #(.CW(CW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .dual_mode_i   (dual_mode_i),
    .pix_upper     (pix_data_o[2*CW-1:CW]),
    .pix_valid_o   (pix_valid_o),
    .vsync_o       (vsync_o),
    .hsync_o       (hsync_o),
    .frame_start_o (frame_start_o)
);

// File: tb/tb_esv_decoder.sv
module tb_esv_decoder;

    localparam int CW = 10;
    localparam int DW = 2 * CW;
    localparam int NV = 43;
    localparam logic [CW-1:0] FILL = 10'h040;

    // [15:12] requirement number, [10] expected valid, [9:0] low-lane word
    localparam logic [15:0] VEC [NV] = '{
        16'h4040, 16'h4040,                       // R4 blanking
        16'h53FF, 16'h5000, 16'h5000, 16'h5280,   // R5 start code, V=1
        16'h5111,                                 // R5 not valid
        16'h53FF, 16'h5000, 16'h5000, 16'h52C0,   // R5 end code
        16'h4040,                                 // R4
        16'h33FF, 16'h3000, 16'h3000, 16'h3200,   // R3 start code, V=0
        16'h3523,                                 // R3 pixel
        16'hA7FF, 16'hA400, 16'hA555,             // R10 partial preamble in line
        16'h36AA,                                 // R3
        16'h33FF, 16'h3000, 16'h3000, 16'h3240,   // R3 end code
        16'h4040,                                 // R4
        16'hA3FF, 16'hA000,                       // R10 partial in blanking
        16'h4040,                                 // R4
        16'h33FF, 16'h3000, 16'h3000, 16'h3200,   // R3 start code
        16'h3401,                                 // R3
        16'hC7FF, 16'hC400, 16'hC400, 16'hC400,   // R12 status MSB 0
        16'h33FF, 16'h3000, 16'h3000, 16'h3240,   // R3 end code
        16'h4040                                  // R4
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          dual_mode_i;
    logic [DW-1:0] data_i;
    logic [DW-1:0] pix_data_o;
    logic          pix_valid_o;
    logic          vsync_o;
    logic          hsync_o;
    logic          field_o;
    logic          frame_start_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    esv_decoder #(.CW(CW)) dut (
        .clk           (clk),
        .rst           (rst),
        .dual_mode_i   (dual_mode_i),
        .data_i        (data_i),
        .pix_data_o    (pix_data_o),
        .pix_valid_o   (pix_valid_o),
        .vsync_o       (vsync_o),
        .hsync_o       (hsync_o),
        .field_o       (field_o),
        .frame_start_o (frame_start_o)
    );

    function automatic string tag_of(input logic [3:0] n);
        case (n)
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd10:   return "R10";
            4'd12:   return "R12";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [CW-1:0] up, input logic [CW-1:0] lo);
        @(negedge clk);
        data_i = {up, lo};
    endtask

    // four code words, one fill word, then stop on the falling edge where flags are due
    task automatic send_code(input logic [CW-1:0] st, input logic [CW-1:0] up);
        step(up, 10'h3FF);
        step(up, 10'h000);
        step(up, 10'h000);
        step(up, st);
        step(10'h000, FILL);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        dual_mode_i = 1'b0;
        data_i      = {10'h000, FILL};
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", pix_valid_o, 0);
        chk("R1 hsync", hsync_o, 0);
        chk("R1 vsync", vsync_o, 1);
        chk("R1 field", field_o, 0);
        chk("R1 frame_start", frame_start_o, 0);

        // table walk: result of entry t-5 is due on iteration t
        for (int t = 0; t < NV + 5; t++) begin
            @(negedge clk);
            if (t >= 5) begin
                chk(tag_of(VEC[t-5][15:12]), pix_valid_o, VEC[t-5][10]);
                if (VEC[t-5][10])
                    chk(tag_of(VEC[t-5][15:12]), pix_data_o, {10'h000, VEC[t-5][9:0]});
            end
            data_i = {10'h000, (t < NV) ? VEC[t][9:0] : FILL};
        end

        // sync regeneration (R2 flag positions, R6, R7, R8, R9)
        do_reset();
        send_code(10'h380, 10'h000);            // start, F=1 V=1
        chk("R6 vsync", vsync_o, 1);
        chk("R7 hsync start", hsync_o, 1);
        chk("R8 field", field_o, 1);
        chk("R9 no pulse in vblank", frame_start_o, 0);
        chk("R5 no valid", pix_valid_o, 0);
        send_code(10'h3C0, 10'h000);            // end, F=1 V=1
        chk("R7 hsync end", hsync_o, 0);
        send_code(10'h200, 10'h000);            // start, F=0 V=0
        chk("R6 vsync low", vsync_o, 0);
        chk("R8 field low", field_o, 0);
        chk("R2 start decode", hsync_o, 1);
        chk("R9 pulse", frame_start_o, 1);
        @(negedge clk);
        chk("R9 one cycle", frame_start_o, 0);
        send_code(10'h240, 10'h000);            // end
        chk("R2 end decode", hsync_o, 0);
        send_code(10'h200, 10'h000);            // second line
        chk("R9 no second pulse", frame_start_o, 0);
        send_code(10'h240, 10'h000);

        // dual lane: high lane carries junk during code, is forwarded in line
        dual_mode_i = 1'b1;
        send_code(10'h200, 10'h155);
        chk("R11 low-lane code in dual", hsync_o, 1);
        step(10'h2CD, 10'h0AB);
        repeat (4) step(10'h000, FILL);
        @(negedge clk);
        chk("R11 dual valid", pix_valid_o, 1);
        chk("R11 dual data", pix_data_o, {10'h2CD, 10'h0AB});
        send_code(10'h240, 10'h000);

        // single lane: high half dropped
        dual_mode_i = 1'b0;
        send_code(10'h200, 10'h000);
        step(10'h2CD, 10'h0AB);
        repeat (4) step(10'h000, FILL);
        @(negedge clk);
        chk("R11 single valid", pix_valid_o, 1);
        chk("R11 single data", pix_data_o, {10'h000, 10'h0AB});
        send_code(10'h240, 10'h000);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule